// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block picks the two source operand values for the instruction that sits in the decode stage of a five-stage in-order pipeline. For each operand it compares the operand's register ID against the destination IDs carried by the execute, memory and write-back stages. When a later stage is about to write the register being read, the block passes that stage's result straight to decode. Otherwise it passes the value just read from the register file.

Five results can be forwarded:
- the ALU result computed in execute during this cycle;
- the memory stage's ALU result;
- the value loaded in the memory stage during this cycle;
- the write-back stage's ALU result;
- the write-back stage's loaded value.

When more than one stage targets the same register, the result of the youngest instruction wins, so decode always sees what sequential execution would give. Register ID all-ones means "no register". A source with that ID never forwards. A destination with that ID is never a write.

The selection is purely combinational. Because the loaded value can be taken from the memory stage in the cycle it is read, a load followed by a dependent instruction costs the stall logic only one cycle.

Top module: `fwd_unit`

## Requirements
- R1: When no stage destination equals a source ID, that operand equals its register-file read value.
- R2: A source ID of all ones (0xF) yields the register-file value even when every destination is also 0xF; a destination of 0xF is never treated as a write.
- R3: When the execute destination equals the source ID, the operand equals the execute ALU result, whatever the memory and write-back stages hold.
- R4: With no execute match, a memory-stage match wins over any write-back match. Within the memory stage, the loaded value (load destination) wins over the ALU result (ALU destination) when both IDs match.
- R5: A memory-stage load destination match forwards the value loaded in that same cycle.
- R6: With no execute or memory match, the write-back loaded value wins over the write-back ALU result, and either wins over the register file.
- R7: The two operands are selected independently. They may take the same source or different sources at once. Register ID 0 is an ordinary register.
- R8: The outputs follow the inputs within the same cycle, with no clock edge between a change of input and the new output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_id_a | input | 4 | Register ID of operand A in decode (0xF = none) |
| src_id_b | input | 4 | Register ID of operand B in decode (0xF = none) |
| rf_val_a | input | DW | Register-file read data for operand A |
| rf_val_b | input | DW | Register-file read data for operand B |
| ex_alu_val | input | DW | ALU result computed in execute this cycle |
| ex_dst_alu | input | 4 | Execute-stage ALU destination ID |
| mem_alu_val | input | DW | ALU result held in the memory stage |
| mem_load_val | input | DW | Value loaded in the memory stage this cycle |
| mem_dst_alu | input | 4 | Memory-stage ALU destination ID |
| mem_dst_load | input | 4 | Memory-stage load destination ID |
| wb_alu_val | input | DW | ALU result held in write-back |
| wb_load_val | input | DW | Loaded value held in write-back |
| wb_dst_alu | input | 4 | Write-back ALU destination ID |
| wb_dst_load | input | 4 | Write-back load destination ID |
| opnd_a | output | DW | Selected value of operand A |
| opnd_b | output | DW | Selected value of operand B |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages on the way. The bench therefore drives a new set of IDs and values just after a rising edge and compares both operands at the following falling edge. In one directed case it changes an input between edges and compares again after a small delay, with no edge in between. The expected value of each operand comes from a source code stored with each vector. The bench maps that code onto the distinct data word it drove for that source.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_ID_W  = 4;
    localparam int NUM_BYP   = 5;
    localparam int NUM_OPND  = 2;
    localparam logic [REG_ID_W-1:0] NO_REG = '1;

    // Bypass order equals priority: index 0 is the youngest result.
    typedef enum logic [2:0] {
        SEL_EX_ALU   = 3'd0,
        SEL_MEM_LOAD = 3'd1,
        SEL_MEM_ALU  = 3'd2,
        SEL_WB_LOAD  = 3'd3,
        SEL_WB_ALU   = 3'd4,
        SEL_REGFILE  = 3'd5
    } fwd_sel_e;

    typedef logic [REG_ID_W-1:0] reg_id_t;

    function automatic logic id_hit(input reg_id_t src, input reg_id_t dst);
        return (src != NO_REG) && (dst != NO_REG) && (src == dst);
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
(
    input  reg_id_t                 src,
    input  reg_id_t [NUM_BYP-1:0]   dsts,
    output logic    [NUM_BYP-1:0]   hit
);

    for (genvar g = 0; g < NUM_BYP; g++) begin : g_cmp
        assign hit[g] = id_hit(src, dsts[g]);
    end

endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_pkg::*;
(
    input  logic [NUM_BYP-1:0] hit,
    output fwd_sel_e           sel
);

    always_comb begin
        sel = SEL_REGFILE;
        for (int i = NUM_BYP - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel = fwd_sel_e'(3'(i));
            end
        end
    end

endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  fwd_sel_e                    sel,
    input  logic [NUM_BYP-1:0][DW-1:0]  byp,
    input  logic [DW-1:0]               rf,
    output logic [DW-1:0]               val
);

    always_comb begin
        val = rf;
        for (int i = 0; i < NUM_BYP; i++) begin
            if (sel == fwd_sel_e'(3'(i))) begin
                val = byp[i];
            end
        end
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [REG_ID_W-1:0] src_id_a,
    input  logic [REG_ID_W-1:0] src_id_b,
    input  logic [DW-1:0]       rf_val_a,
    input  logic [DW-1:0]       rf_val_b,
    input  logic [DW-1:0]       ex_alu_val,
    input  logic [REG_ID_W-1:0] ex_dst_alu,
    input  logic [DW-1:0]       mem_alu_val,
    input  logic [DW-1:0]       mem_load_val,
    input  logic [REG_ID_W-1:0] mem_dst_alu,
    input  logic [REG_ID_W-1:0] mem_dst_load,
    input  logic [DW-1:0]       wb_alu_val,
    input  logic [DW-1:0]       wb_load_val,
    input  logic [REG_ID_W-1:0] wb_dst_alu,
    input  logic [REG_ID_W-1:0] wb_dst_load,
    output logic [DW-1:0]       opnd_a,
    output logic [DW-1:0]       opnd_b
);

    reg_id_t    [NUM_BYP-1:0]           byp_dst;
    logic       [NUM_BYP-1:0][DW-1:0]   byp_val;
    reg_id_t    [NUM_OPND-1:0]          src;
    logic       [NUM_OPND-1:0][DW-1:0]  rf;
    logic       [NUM_OPND-1:0][DW-1:0]  res;

    // Pack bypass sources youngest first so index equals priority.
    assign byp_dst[SEL_EX_ALU]   = ex_dst_alu;
    assign byp_dst[SEL_MEM_LOAD] = mem_dst_load;
    assign byp_dst[SEL_MEM_ALU]  = mem_dst_alu;
    assign byp_dst[SEL_WB_LOAD]  = wb_dst_load;
    assign byp_dst[SEL_WB_ALU]   = wb_dst_alu;

    assign byp_val[SEL_EX_ALU]   = ex_alu_val;
    assign byp_val[SEL_MEM_LOAD] = mem_load_val;
    assign byp_val[SEL_MEM_ALU]  = mem_alu_val;
    assign byp_val[SEL_WB_LOAD]  = wb_load_val;
    assign byp_val[SEL_WB_ALU]   = wb_alu_val;

    assign src[0] = src_id_a;
    assign src[1] = src_id_b;
    assign rf[0]  = rf_val_a;
    assign rf[1]  = rf_val_b;

    for (genvar op = 0; op < NUM_OPND; op++) begin : g_opnd
        logic [NUM_BYP-1:0] hit;
        fwd_sel_e           sel;

        fwd_match u_match (
            .src  (src[op]),
            .dsts (byp_dst),
            .hit  (hit)
        );

        fwd_prio u_prio (
            .hit (hit),
            .sel (sel)
        );

        fwd_mux #(.DW(DW)) u_mux (
            .sel (sel),
            .byp (byp_val),
            .rf  (rf[op]),
            .val (res[op])
        );
    end

    assign opnd_a = res[0];
    assign opnd_b = res[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input logic [REG_ID_W-1:0] src_id_a,
    input logic [REG_ID_W-1:0] src_id_b,
    input logic [DW-1:0]       rf_val_a,
    input logic [DW-1:0]       rf_val_b,
    input logic [DW-1:0]       ex_alu_val,
    input logic [REG_ID_W-1:0] ex_dst_alu,
    input logic [DW-1:0]       mem_alu_val,
    input logic [DW-1:0]       mem_load_val,
    input logic [REG_ID_W-1:0] mem_dst_alu,
    input logic [REG_ID_W-1:0] mem_dst_load,
    input logic [DW-1:0]       wb_alu_val,
    input logic [DW-1:0]       wb_load_val,
    input logic [REG_ID_W-1:0] wb_dst_alu,
    input logic [REG_ID_W-1:0] wb_dst_load,
    input logic [DW-1:0]       opnd_a,
    input logic [DW-1:0]       opnd_b
);

    logic a_valid, b_valid, a_any, b_any;

    assign a_valid = (src_id_a != 4'hF);
    assign b_valid = (src_id_b != 4'hF);
    assign a_any = a_valid && ((ex_dst_alu == src_id_a) || (mem_dst_alu == src_id_a) ||
                   (mem_dst_load == src_id_a) || (wb_dst_alu == src_id_a) ||
                   (wb_dst_load == src_id_a));
    assign b_any = b_valid && ((ex_dst_alu == src_id_b) || (mem_dst_alu == src_id_b) ||
                   (mem_dst_load == src_id_b) || (wb_dst_alu == src_id_b) ||
                   (wb_dst_load == src_id_b));

    always_comb begin
        a_r1_rf_a: assert (a_any || opnd_a == rf_val_a)
            else $error("R1 operand A not from register file");
        a_r1_rf_b: assert (b_any || opnd_b == rf_val_b)
            else $error("R1 operand B not from register file");
        a_r2_null_a: assert (a_valid || opnd_a == rf_val_a)
            else $error("R2 null source A forwarded");
        a_r3_ex_first_a: assert (!(a_valid && ex_dst_alu == src_id_a) || opnd_a == ex_alu_val)
            else $error("R3 execute result not chosen for A");
        a_r3_ex_first_b: assert (!(b_valid && ex_dst_alu == src_id_b) || opnd_b == ex_alu_val)
            else $error("R3 execute result not chosen for B");
        a_r5_mem_load_a: assert (!(a_valid && ex_dst_alu != src_id_a && mem_dst_load == src_id_a)
                                 || opnd_a == mem_load_val)
            else $error("R5 loaded value not chosen for A");
        a_r6_wb_load_a: assert (!(a_valid && ex_dst_alu != src_id_a && mem_dst_load != src_id_a &&
                                  mem_dst_alu != src_id_a && wb_dst_load == src_id_a)
                                || opnd_a == wb_load_val)
            else $error("R6 write-back loaded value not chosen for A");
    end

endmodule

bind fwd_unit fwd_unit_chk #(.DW(DW)) u_chk (
    .src_id_a     (src_id_a),
    .src_id_b     (src_id_b),
    .rf_val_a     (rf_val_a),
    .rf_val_b     (rf_val_b),
    .ex_alu_val   (ex_alu_val),
    .ex_dst_alu   (ex_dst_alu),
    .mem_alu_val  (mem_alu_val),
    .mem_load_val (mem_load_val),
    .mem_dst_alu  (mem_dst_alu),
    .mem_dst_load (mem_dst_load),
    .wb_alu_val   (wb_alu_val),
    .wb_load_val  (wb_load_val),
    .wb_dst_alu   (wb_dst_alu),
    .wb_dst_load  (wb_dst_load),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;

    localparam int DW = 32;
    localparam int NV = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [3:0]    src_id_a, src_id_b, ex_dst_alu, mem_dst_alu, mem_dst_load, wb_dst_alu, wb_dst_load;
    logic [DW-1:0] rf_val_a, rf_val_b, ex_alu_val, mem_alu_val, mem_load_val, wb_alu_val, wb_load_val;
    logic [DW-1:0] opnd_a, opnd_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    fwd_unit #(.DW(DW)) dut (.*);

    // Source codes: 0 ex ALU, 1 mem load, 2 mem ALU, 3 wb load, 4 wb ALU, 5 register file
    // Entry: {src_a, src_b, ex_alu, mem_alu, mem_load, wb_alu, wb_load, exp_a, exp_b}
    localparam logic [33:0] VEC [NV] = '{
        {4'h1, 4'h2, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 3'd5, 3'd5},  // R1
        {4'h1, 4'h2, 4'h1, 4'hF, 4'hF, 4'hF, 4'hF, 3'd0, 3'd5},  // R3
        {4'h1, 4'h2, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 3'd0, 3'd5},  // R3
        {4'h1, 4'h4, 4'hF, 4'h1, 4'h1, 4'h1, 4'h1, 3'd1, 3'd5},  // R4
        {4'h1, 4'h4, 4'hF, 4'h1, 4'hF, 4'hF, 4'h1, 3'd2, 3'd5},  // R4
        {4'h1, 4'h2, 4'hF, 4'hF, 4'h2, 4'hF, 4'hF, 3'd5, 3'd1},  // R5
        {4'h3, 4'h2, 4'hF, 4'hF, 4'hF, 4'h3, 4'h3, 3'd3, 3'd5},  // R6
        {4'h3, 4'h2, 4'hF, 4'hF, 4'hF, 4'h3, 4'hF, 3'd4, 3'd5},  // R6
        {4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 3'd5, 3'd5},  // R2
        {4'h1, 4'h1, 4'h1, 4'hF, 4'hF, 4'hF, 4'hF, 3'd0, 3'd0},  // R7
        {4'h2, 4'h3, 4'h2, 4'hF, 4'hF, 4'h3, 4'hF, 3'd0, 3'd4},  // R7
        {4'h0, 4'h5, 4'h0, 4'h5, 4'hF, 4'hF, 4'hF, 3'd0, 3'd2},  // R7
        {4'hE, 4'hF, 4'hF, 4'hF, 4'hF, 4'hE, 4'hE, 3'd3, 3'd5}   // R6
    };

    function automatic logic [DW-1:0] pick(input logic [2:0] code, input logic [DW-1:0] rf);
        case (code)
            3'd0: return ex_alu_val;
            3'd1: return mem_load_val;
            3'd2: return mem_alu_val;
            3'd3: return wb_load_val;
            3'd4: return wb_alu_val;
            default: return rf;
        endcase
    endfunction

    task automatic set_data(input int k);
        rf_val_a     = 32'hA000_0001 ^ DW'(k << 8);
        rf_val_b     = 32'hB000_0002 ^ DW'(k << 8);
        ex_alu_val   = 32'hE000_0003 ^ DW'(k << 8);
        mem_alu_val  = 32'h4000_0004 ^ DW'(k << 8);
        mem_load_val = 32'h5000_0005 ^ DW'(k << 8);
        wb_alu_val   = 32'h6000_0006 ^ DW'(k << 8);
        wb_load_val  = 32'h7000_0007 ^ DW'(k << 8);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        {src_id_a, src_id_b, ex_dst_alu, mem_dst_alu, mem_dst_load, wb_dst_alu, wb_dst_load} = '1;
        set_data(0);
        repeat (3) @(posedge clk);
        // Idle state during reset: no operands, no writes (R2)
        @(negedge clk);
        check("R2 idle A", opnd_a, rf_val_a);
        check("R2 idle B", opnd_b, rf_val_b);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #1;
            {src_id_a, src_id_b, ex_dst_alu, mem_dst_alu, mem_dst_load, wb_dst_alu, wb_dst_load}
                = VEC[i][33:6];
            set_data(i + 1);
            @(negedge clk);
            check($sformatf("R1-table vec %0d A", i), opnd_a, pick(VEC[i][5:3], rf_val_a));
            check($sformatf("R7 vec %0d B", i), opnd_b, pick(VEC[i][2:0], rf_val_b));
        end

        // R8: change inputs between edges, result follows without a clock edge
        @(posedge clk);
        #1;
        {src_id_a, src_id_b, ex_dst_alu, mem_dst_alu, mem_dst_load, wb_dst_alu, wb_dst_load} = '1;
        src_id_a = 4'h6; src_id_b = 4'h7;
        set_data(40);
        #1;
        check("R8 before A", opnd_a, rf_val_a);
        mem_dst_load = 4'h6;
        #1;
        check("R8 after A (R5)", opnd_a, mem_load_val);
        ex_dst_alu = 4'h7;
        #1;
        check("R8 after B (R3)", opnd_b, ex_alu_val);

        // R2: destination 0xF is no write even for a valid source
        src_id_a = 4'h9;
        {ex_dst_alu, mem_dst_alu, mem_dst_load, wb_dst_alu, wb_dst_load} = '1;
        #1;
        check("R2 dst none A", opnd_a, rf_val_a);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule